// File: doc/BRIEF.md
# OTP Mirror CRC Integrity Checker

This block guards a small bank of mirror registers that hold working copies of one-time-programmable fuse values. After a power-on reset, or when a clear command arrives, an automatic readout copies the fuse bits into the mirrors and samples a lock bit. From then on a serial engine walks every mirror bit, one bit per clock, and folds the bits into a 3-bit CRC. At the end of each walk the result is compared with a 3-bit CRC field that is stored inside the mirror bank itself.

The check only counts when the lock sampled at readout was 1. In that case a mismatch sets a sticky data-error flag. A register write port may change any mirror at any time, lock or no lock. Such writes alter what the engine computes, and a write in the middle of a walk makes the walk start again. Only a reset or a clear command clears the flag. A clear also reloads the mirrors from the fuses and samples the lock again.

Top module: `otp_mirror_crc_check`

## Requirements
- R1: While `rst` is high, `data_err` and `lock_active` are both 0 at every clock edge.
- R2: Readout takes place on the first clock edge after `rst` falls, and on the edge after the edge that samples `clear_cmd`. It loads mirror k from `fuse_bits[k*REG_W +: REG_W]` and loads `lock_active` from fuse bit 15 (register 1, bit 7). Changes to `fuse_bits` at any other time have no effect.
- R3: The CRC uses the generator x^3+x+1 and starts each walk at 111. It takes bits least significant first within a register, and registers in ascending address order. It skips the stored field, which is register 0 bits [2:0], and compares the result with that field. A consistent locked bank never raises `data_err`.
- R4: With `lock_active` high, a mismatch raises `data_err` within 2*TOT+4 cycles, where TOT = NUM_REGS*REG_W.
- R5: With `lock_active` low, `data_err` stays 0 whatever the mirror contents.
- R6: Writes (`wr_en`, `wr_addr`, `wr_data`) update the addressed mirror whatever the lock state, and the next completed walk checks the new contents.
- R7: Once set, `data_err` stays 1 until a reset or a clear command, even if the mirrors are corrected.
- R8: On the edge that samples `clear_cmd`, `data_err` and `lock_active` go to 0. The readout that follows discards all earlier writes.
- R9: A write restarts the walk. If writes arrive less than TOT cycles apart, no comparison is made, and `data_err` cannot rise in the cycle that follows the cycle after a write.
- R10: A write that occurs in the same cycle as a readout is discarded.
- R11: Writing 1 into the mirror copy of the lock bit does not make `lock_active` true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clear_cmd | input | 1 | One-cycle clear command pulse |
| fuse_bits | input | NUM_REGS*REG_W | Fuse values, register k in bits [k*REG_W +: REG_W] |
| wr_en | input | 1 | Mirror write strobe |
| wr_addr | input | $clog2(NUM_REGS) | Mirror register address |
| wr_data | input | REG_W | Mirror write data |
| data_err | output | 1 | Sticky CRC data-error flag |
| lock_active | output | 1 | Lock as sampled at the last readout |

## Verification
The assertions assume that `clear_cmd` is a synchronous pulse and that `rst` is high at the first clock edge. The readout check assumes that `fuse_bits` is stable over the cycle in which readout samples it. The bench drives all inputs on falling edges, holds `rst` for several cycles from time zero, and changes `fuse_bits` only well before a clear. For the random cases, fuse images are built with a correct or a deliberately wrong stored CRC and with a random lock. Random writes follow, each one spaced by a full walk, so the sticky expected flag can be updated once per completed walk.

// File: rtl/otpm_pkg.sv
package otpm_pkg;

  localparam int CRC_W = 3;

  typedef logic [CRC_W-1:0] crc3_t;

  localparam crc3_t CRC_SEED = 3'b111;

  // one serial step of x^3 + x + 1, shifting toward the top bit
  function automatic crc3_t crc3_step(input crc3_t cur, input logic din);
    logic fb;
    fb = cur[2] ^ din;
    return {cur[1], cur[0] ^ fb, fb};
  endfunction

endpackage

// File: rtl/otpm_mirror_bank.sv
module otpm_mirror_bank #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int TOT     = NUM_REGS * REG_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [TOT-1:0] fuse_bits,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [TOT-1:0] mirror_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (load) begin
        q <= fuse_bits[g*REG_W +: REG_W];
      end else if (wr_en && (wr_addr == AW'(g))) begin
        q <= wr_data;
      end
    end

    assign mirror_flat[g*REG_W +: REG_W] = q;
  end

endmodule

// File: rtl/otpm_crc_engine.sv
module otpm_crc_engine
  import otpm_pkg::*;
#(
  parameter int TOT     = 32,
  parameter int CRC_POS = 0,
  localparam int CW     = $clog2(TOT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic [TOT-1:0] data_flat,
  output logic           pass_done,
  output logic           mismatch
);

  localparam logic [CW-1:0]  LAST      = CW'(TOT - 1);
  localparam logic [TOT-1:0] SKIP_MASK = {{(TOT-CRC_W){1'b0}}, {CRC_W{1'b1}}} << CRC_POS;

  logic [CW-1:0] cnt;
  crc3_t         crc_q;
  crc3_t         crc_nxt;

  always_comb begin
    if (SKIP_MASK[cnt]) crc_nxt = crc_q;
    else                crc_nxt = crc3_step(crc_q, data_flat[cnt]);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt       <= '0;
      crc_q     <= CRC_SEED;
      pass_done <= 1'b0;
      mismatch  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt       <= '0;
      crc_q     <= CRC_SEED;
      pass_done <= 1'b1;
      mismatch  <= (crc_nxt != data_flat[CRC_POS +: CRC_W]);
    end else begin
      cnt       <= cnt + 1'b1;
      crc_q     <= crc_nxt;
      pass_done <= 1'b0;
    end
  end

endmodule

// File: rtl/otpm_lock_ctrl.sv
module otpm_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clear_cmd,
  input  logic fuse_lock,
  input  logic pass_done,
  input  logic mismatch,
  output logic load,
  output logic lock_active,
  output logic data_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      load        <= 1'b1;
      lock_active <= 1'b0;
      data_err    <= 1'b0;
    end else begin
      load <= clear_cmd;
      if (clear_cmd)  lock_active <= 1'b0;
      else if (load)  lock_active <= fuse_lock;

      if (clear_cmd || load)
        data_err <= 1'b0;
      else if (pass_done && mismatch && lock_active)
        data_err <= 1'b1;
    end
  end

endmodule

// File: rtl/otp_mirror_crc_check.sv
module otp_mirror_crc_check #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int CRC_REG  = 0,
  parameter int CRC_LSB  = 0,
  parameter int LOCK_REG = 1,
  parameter int LOCK_BIT = 7,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int TOT     = NUM_REGS * REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_cmd,
  input  logic [TOT-1:0]   fuse_bits,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             data_err,
  output logic             lock_active
);

  localparam int CRC_POS  = CRC_REG * REG_W + CRC_LSB;
  localparam int LOCK_POS = LOCK_REG * REG_W + LOCK_BIT;

  logic           load;
  logic           pass_done;
  logic           mismatch;
  logic [TOT-1:0] mirror_flat;
  logic           restart;

  assign restart = load | clear_cmd | wr_en;

  otpm_mirror_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) i_bank (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .fuse_bits   (fuse_bits),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .mirror_flat (mirror_flat)
  );

  otpm_crc_engine #(.TOT(TOT), .CRC_POS(CRC_POS)) i_engine (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .data_flat (mirror_flat),
    .pass_done (pass_done),
    .mismatch  (mismatch)
  );

  otpm_lock_ctrl i_lock (
    .clk         (clk),
    .rst         (rst),
    .clear_cmd   (clear_cmd),
    .fuse_lock   (fuse_bits[LOCK_POS]),
    .pass_done   (pass_done),
    .mismatch    (mismatch),
    .load        (load),
    .lock_active (lock_active),
    .data_err    (data_err)
  );

endmodule

// File: rtl/otpm_crc_check_sva.sv
module otpm_crc_check_sva (
  input logic clk,
  input logic rst,
  input logic clear_cmd,
  input logic fuse_lock,
  input logic wr_en,
  input logic data_err,
  input logic lock_active
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!data_err && !lock_active)); // R1

  AST_READOUT_LOCK: assert property (@(posedge clk) disable iff (rst)
    clear_cmd ##1 !clear_cmd |=> (lock_active == $past(fuse_lock))); // R2

  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(data_err) |-> $past(lock_active)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (data_err && !clear_cmd) |=> data_err); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    clear_cmd |=> (!data_err && !lock_active)); // R8

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ##1 !$rose(data_err)); // R9

endmodule

bind otp_mirror_crc_check otpm_crc_check_sva i_sva (
  .clk         (clk),
  .rst         (rst),
  .clear_cmd   (clear_cmd),
  .fuse_lock   (fuse_bits[LOCK_POS]),
  .wr_en       (wr_en),
  .data_err    (data_err),
  .lock_active (lock_active)
);

// File: tb/test_otp_mirror_crc_check.sv
`timescale 1ns/1ps
module test_otp_mirror_crc_check;

  localparam int NUM_REGS = 4;
  localparam int REG_W    = 8;
  localparam int TOT      = NUM_REGS * REG_W;
  localparam int LOCK_IX  = 15;
  localparam int PASS_WAIT = 2 * TOT + 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           clear_cmd = 1'b0;
  logic [TOT-1:0] fuse_bits = '0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic           data_err;
  logic           lock_active;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [TOT-1:0] model;
  logic           m_lock;
  logic           exp_err;

  always #10 clk = ~clk;

  otp_mirror_crc_check i_otp_mirror_crc_check (
    .clk(clk), .rst(rst), .clear_cmd(clear_cmd), .fuse_bits(fuse_bits),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .data_err(data_err), .lock_active(lock_active)
  );

  // CRC from the requirement: x^3+x+1, seed 111, LSB first, field bits 2:0 skipped
  function automatic logic [2:0] ref_crc(input logic [TOT-1:0] img);
    logic [2:0] c = 3'b111;
    for (int i = 3; i < TOT; i++) begin
      logic top;
      top = c[2] ^ img[i];
      c = {c[1], c[0] ^ top, top};
    end
    return c;
  endfunction

  function automatic logic is_bad(input logic [TOT-1:0] img);
    return ref_crc(img) != img[2:0];
  endfunction

  function automatic logic [TOT-1:0] make_fuse(input logic lk, input logic good);
    logic [TOT-1:0] f;
    logic [2:0] c;
    f = TOT'($urandom);
    f[LOCK_IX] = lk;
    c = ref_crc(f);
    f[2:0] = good ? c : (c ^ 3'($urandom_range(1, 7)));
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic wait_pass();
    repeat (PASS_WAIT) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a*8 +: 8] = d;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_cmd = 1'b1;
    @(negedge clk);
    clear_cmd = 1'b0;
    chk("R8 err after clear", 32'(data_err), 32'd0);
    chk("R8 lock after clear", 32'(lock_active), 32'd0);
    @(negedge clk);
    model = fuse_bits; m_lock = fuse_bits[LOCK_IX]; exp_err = 1'b0;
    chk("R2 lock after clear readout", 32'(lock_active), 32'(m_lock));
  endtask

  task automatic do_reset(input logic [TOT-1:0] f);
    @(negedge clk);
    fuse_bits = f;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 err in reset", 32'(data_err), 32'd0);
    chk("R1 lock in reset", 32'(lock_active), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    model = f; m_lock = f[LOCK_IX]; exp_err = 1'b0;
    chk("R2 lock after reset readout", 32'(lock_active), 32'(m_lock));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [TOT-1:0] f;
    logic [7:0] orig;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);

    // R1 R2 R3: locked, consistent bank
    f = make_fuse(1'b1, 1'b1);
    do_reset(f);
    wait_pass();
    chk("R3 consistent locked bank", 32'(data_err), 32'd0);

    // R2: fuse change without readout ignored
    @(negedge clk);
    fuse_bits = f ^ 32'h0000_0100;
    wait_pass();
    chk("R2 fuse ignored without readout", 32'(data_err), 32'd0);

    // R4: locked bad CRC
    do_reset(make_fuse(1'b1, 1'b0));
    wait_pass();
    chk("R4 locked mismatch flags", 32'(data_err), 32'd1);

    // R5: unlocked bad CRC
    do_reset(make_fuse(1'b0, 1'b0));
    wait_pass();
    chk("R5 unlocked mismatch silent", 32'(data_err), 32'd0);

    // R11: write lock bit in mirror, still not armed
    do_write(2'd1, model[15:8] | 8'h80);
    wait_pass();
    chk("R11 lock stays low", 32'(lock_active), 32'd0);
    chk("R11 no error", 32'(data_err), 32'd0);

    // R6 R7: locked good, corrupt by write, then repair
    f = make_fuse(1'b1, 1'b1);
    do_reset(f);
    orig = f[23:16];
    do_write(2'd2, orig ^ 8'h01);
    wait_pass();
    chk("R6 write checked", 32'(data_err), 32'd1);
    do_write(2'd2, orig);
    wait_pass();
    chk("R7 sticky after repair", 32'(data_err), 32'd1);

    // R8: clear reloads fuses, drops writes
    do_write(2'd3, f[31:24] ^ 8'h10);
    do_clear();
    wait_pass();
    chk("R8 reload discards writes", 32'(data_err), 32'd0);

    // R9: frequent writes block comparison
    for (int k = 0; k < 12; k++) begin
      do_write(2'd2, orig ^ 8'h01);
      repeat (8) @(negedge clk);
    end
    chk("R9 no compare during writes", 32'(data_err), 32'd0);
    wait_pass();
    chk("R9 compare after writes stop", 32'(data_err), 32'd1);

    // R10: write in readout cycle discarded
    @(negedge clk);
    fuse_bits = f;
    clear_cmd = 1'b1;
    @(negedge clk);
    clear_cmd = 1'b0;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = orig ^ 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    model = f; m_lock = 1'b1; exp_err = 1'b0;
    wait_pass();
    chk("R10 readout wins over write", 32'(data_err), 32'd0);

    // random phase: R3 R4 R5 R6 R7
    for (int it = 0; it < 24; it++) begin
      @(negedge clk);
      fuse_bits = make_fuse(1'($urandom), 1'($urandom));
      do_clear();
      wait_pass();
      exp_err = m_lock && is_bad(model);
      chk("R3/R4 random image", 32'(data_err), 32'(exp_err));
      for (int w = 0; w < 3; w++) begin
        do_write(2'($urandom), 8'($urandom));
        wait_pass();
        exp_err = exp_err | (m_lock && is_bad(model));
        chk("R6/R7 random write", 32'(data_err), 32'(exp_err));
      end
    end

    finish_run();
  end

endmodule